// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This engine serves the host side of a frame transmitter. The host builds a circular ring of transmit descriptors in a shared word-addressed memory. Each descriptor points to one buffer that holds one whole frame. The host hands a descriptor to the engine by setting its ownership bit, then pulses `demand`. The engine reads the current descriptor. If it owns it, the engine fetches the buffer one 32-bit word at a time and streams the frame out as bytes over a valid/ready handshake. Short frames are zero-filled to the minimum length when auto-pad is on.

When the last byte is accepted, the engine samples the error flags the line side reports alongside `tx_ready`. It writes a per-descriptor error report into the descriptor's third word. It then rewrites the status word with ownership returned to the host and sets the transmit interrupt flag. It moves on to the next entry at once, and keeps going until it reaches an entry it does not own. There it goes idle until the next demand. A `start` pulse enables the engine and moves the ring pointer back to the base.

Memory reads have a fixed latency of one cycle: `mem_rdata` holds the word addressed in the previous cycle in which `mem_en` was high and `mem_we` low.

Top module: `tdr_engine`

## Requirements
- R1: During and after reset, `tx_valid`, `tx_int` and `mem_en` are low, the engine is disabled and the ring index is 0.
- R2: A `demand` pulse before the first `start` causes no memory access. A `start` pulse enables the engine, aborts any activity and returns the ring index to 0, so the next demand polls entry 0.
- R3: On `demand` the engine reads the status word of the current entry. If bit 31 (ownership) is clear, it performs no further access and emits nothing until the next `demand`.
- R4: For an owned entry the byte count is the two's complement of status bits 15:0. The bytes come from the buffer whose word address is held in descriptor word 0. Byte k of a word is in bits 8k+7:8k. `tx_last` marks the final byte.
- R5: With `autopad_en` high, a frame of fewer than MIN_LEN (60) bytes is extended to exactly MIN_LEN bytes with zero bytes. A longer frame, or any frame with `autopad_en` low, is sent with exactly its byte count.
- R6: After the frame, descriptor word 2 is written with the line error flags and all other bits zero. The flags map as `phy_err` bit 0 (retry failure) to bit 26, bit 1 (carrier loss) to 27, bit 2 (late collision) to 28, bit 3 (underflow) to 30 and bit 4 (buffer error) to 31. Word 1 is then rewritten with bit 31 cleared, bit 30 set to the OR of the flags, and all other bits unchanged. Word 2 is written before word 1.
- R7: `tx_int` rises in the cycle after the word 1 write-back. It stays high until an `int_ack` pulse clears it.
- R8: After a write-back the engine advances to the next entry and polls it without a new demand. The index wraps to 0 after 2^L entries, where L is `ring_log` limited to LOG_MAX.
- R9: Entry i occupies words `ring_base`+4i to `ring_base`+4i+2, holding buffer address, status and error report. `ring_base` is a multiple of 4.
- R10: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Enable pulse; ring index to base |
| demand | input | 1 | Transmit-demand pulse |
| autopad_en | input | 1 | Zero-fill short frames to MIN_LEN |
| ring_log | input | 4 | Log2 of ring entries |
| ring_base | input | AW | Word address of entry 0 |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| tx_valid | output | 1 | Byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Line side accepts byte |
| phy_err | input | 5 | Line error flags, sampled with the last byte |
| tx_int | output | 1 | Transmit interrupt flag |
| int_ack | input | 1 | Clears `tx_int` |

## Verification
The bench builds the engine with its defaults: AW=8 (a 256-word memory), LOG_MAX=4 and MIN_LEN=60. It drives `ring_log` to 2 and `ring_base` to 16, so the fifth frame wraps back to entry 0 and a non-zero base tests the descriptor addressing. Frames of 5, 10, 59, 61 and 70 bytes, with auto-pad on and off, cover both sides of the padding limit and buffers that end inside a word. Random backpressure on `tx_ready` exercises the hold rule, and varied error patterns check every write-back bit.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_POLL, S_CHK, S_PTR, S_PTRW,
        S_FETCH, S_LOAD, S_EMIT, S_WB2, S_WB1
    } tdr_state_e;

    // Line-side error flags, bit 0 = retry failure ... bit 4 = buffer error
    typedef struct packed {
        logic buff;
        logic uflo;
        logic lcol;
        logic lcar;
        logic rtry;
    } phy_err_t;

    localparam int OWN_BIT  = 31;
    localparam int ERR_BIT  = 30;
    localparam int RTRY_POS = 26;
    localparam int LCAR_POS = 27;
    localparam int LCOL_POS = 28;
    localparam int UFLO_POS = 30;
    localparam int BUFF_POS = 31;

    function automatic logic [31:0] err_report(phy_err_t e);
        logic [31:0] w;
        w = '0;
        w[RTRY_POS] = e.rtry;
        w[LCAR_POS] = e.lcar;
        w[LCOL_POS] = e.lcol;
        w[UFLO_POS] = e.uflo;
        w[BUFF_POS] = e.buff;
        return w;
    endfunction

    function automatic logic [15:0] neg16(logic [15:0] v);
        return ~v + 16'd1;
    endfunction

endpackage

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
    parameter int AW      = 8,
    parameter int LOG_MAX = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                advance,
    input  logic [3:0]          ring_log,
    input  logic [AW-1:0]       ring_base,
    output logic [AW-1:0]       desc_addr
);
    localparam int PADW = AW - LOG_MAX - 2;

    logic [LOG_MAX-1:0] idx_q;
    logic [LOG_MAX-1:0] mask;
    int                 eff_log;

    always_comb begin
        eff_log = (int'(ring_log) > LOG_MAX) ? LOG_MAX : int'(ring_log);
        mask = '0;
        for (int b = 0; b < LOG_MAX; b++) begin
            if (b < eff_log) mask[b] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= (idx_q + LOG_MAX'(1)) & mask;
        end
    end

    assign desc_addr = ring_base + {{PADW{1'b0}}, idx_q, 2'b00};

endmodule

// File: rtl/tdr_frame_shaper.sv
module tdr_frame_shaper #(
    parameter int MIN_LEN = 60
) (
    input  logic [15:0] bcnt,
    input  logic        autopad,
    input  logic [15:0] cnt,
    input  logic [31:0] word,
    output logic        in_buf,
    output logic        is_last,
    output logic [7:0]  byte_out
);
    logic [15:0] total;
    logic [7:0]  lane;

    always_comb begin
        if (autopad && bcnt < 16'(MIN_LEN)) total = 16'(MIN_LEN);
        else if (bcnt == 16'd0)             total = 16'd1;
        else                                total = bcnt;
    end

    assign in_buf   = cnt < bcnt;
    assign is_last  = cnt == total - 16'd1;
    assign lane     = word[8*cnt[1:0] +: 8];
    assign byte_out = in_buf ? lane : 8'h00;

endmodule

// File: rtl/tdr_engine.sv
module tdr_engine
    import tdr_pkg::*;
#(
    parameter int AW      = 8,
    parameter int LOG_MAX = 4,
    parameter int MIN_LEN = 60
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          demand,
    input  logic          autopad_en,
    input  logic [3:0]    ring_log,
    input  logic [AW-1:0] ring_base,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic [4:0]    phy_err,
    output logic          tx_int,
    input  logic          int_ack
);
    localparam logic [AW-1:0] OFS_STAT = AW'(1);
    localparam logic [AW-1:0] OFS_REP  = AW'(2);

    tdr_state_e    state;
    logic          running;
    logic [31:0]   md1_q;
    logic [AW-1:0] buf_q;
    logic [31:0]   word_q;
    logic [15:0]   cnt_q;
    phy_err_t      err_q;

    logic [AW-1:0] desc_addr;
    logic          in_buf;
    logic          is_last;
    logic [7:0]    shaped_byte;
    logic [15:0]   bcnt;
    logic [AW-1:0] word_ofs;
    logic [31:0]   md1_done;

    assign bcnt     = neg16(md1_q[15:0]);
    assign word_ofs = cnt_q[AW+1:2];

    tdr_ring_ptr #(.AW(AW), .LOG_MAX(LOG_MAX)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .advance   (state == S_WB1),
        .ring_log  (ring_log),
        .ring_base (ring_base),
        .desc_addr (desc_addr)
    );

    tdr_frame_shaper #(.MIN_LEN(MIN_LEN)) u_shape (
        .bcnt     (bcnt),
        .autopad  (autopad_en),
        .cnt      (cnt_q),
        .word     (word_q),
        .in_buf   (in_buf),
        .is_last  (is_last),
        .byte_out (shaped_byte)
    );

    always_comb begin
        md1_done          = md1_q;
        md1_done[OWN_BIT] = 1'b0;
        md1_done[ERR_BIT] = |err_q;
    end

    // Memory port decode
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        unique case (state)
            S_POLL: begin
                mem_en   = 1'b1;
                mem_addr = desc_addr + OFS_STAT;
            end
            S_PTR: begin
                mem_en   = 1'b1;
                mem_addr = desc_addr;
            end
            S_FETCH: begin
                mem_en   = in_buf;
                mem_addr = buf_q + word_ofs;
            end
            S_WB2: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + OFS_REP;
                mem_wdata = err_report(err_q);
            end
            S_WB1: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + OFS_STAT;
                mem_wdata = md1_done;
            end
            default: ;
        endcase
    end

    assign tx_valid = state == S_EMIT;
    assign tx_data  = tx_valid ? shaped_byte : 8'h00;
    assign tx_last  = tx_valid && is_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            running <= 1'b0;
            md1_q   <= '0;
            buf_q   <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
            err_q   <= '0;
        end else if (start) begin
            state   <= S_IDLE;
            running <= 1'b1;
        end else begin
            unique case (state)
                S_IDLE:  if (demand && running) state <= S_POLL;
                S_POLL:  state <= S_CHK;
                S_CHK: begin
                    if (mem_rdata[OWN_BIT]) begin
                        md1_q <= mem_rdata;
                        state <= S_PTR;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                S_PTR:   state <= S_PTRW;
                S_PTRW: begin
                    buf_q <= mem_rdata[AW-1:0];
                    cnt_q <= '0;
                    state <= S_FETCH;
                end
                S_FETCH: begin
                    if (in_buf) begin
                        state <= S_LOAD;
                    end else begin
                        word_q <= '0;
                        state  <= S_EMIT;
                    end
                end
                S_LOAD: begin
                    word_q <= mem_rdata;
                    state  <= S_EMIT;
                end
                S_EMIT: begin
                    if (tx_ready) begin
                        cnt_q <= cnt_q + 16'd1;
                        if (is_last) begin
                            err_q <= phy_err_t'(phy_err);
                            state <= S_WB2;
                        end else if (cnt_q[1:0] == 2'b11) begin
                            state <= S_FETCH;
                        end
                    end
                end
                S_WB2:   state <= S_WB1;
                S_WB1:   state <= S_POLL;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  tx_int <= 1'b0;
        else if (state == S_WB1)  tx_int <= 1'b1;
        else if (int_ack)         tx_int <= 1'b0;
    end

endmodule

// File: rtl/tdr_engine_chk.sv
module tdr_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        int_ack,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        tx_int,
    input logic        mem_en,
    input logic        mem_we,
    input logic [31:0] mem_wdata
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_valid && !tx_int && !mem_en));

    // R2
    start_abort_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!tx_valid && !mem_we));

    // R7
    int_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_int) |-> $past(mem_en && mem_we && !mem_wdata[31]));

    // R7
    int_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !mem_we) |=> !tx_int);

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !start) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_last)));

endmodule

bind tdr_engine tdr_engine_chk u_tdr_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .int_ack   (int_ack),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_int    (tx_int),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/tdr_engine_bench.sv
module tdr_engine_bench;
    localparam int AW   = 8;
    localparam int BASE = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, demand = 1'b0, autopad_en = 1'b1, int_ack = 1'b0;
    logic [3:0]    ring_log = 4'd2;
    logic [AW-1:0] ring_base = AW'(BASE);
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          tx_valid, tx_last, tx_int;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b0;
    logic [4:0]    phy_err = '0;

    logic [31:0] mem [0:255];
    logic [8:0]  exp_q[$];
    logic [4:0]  err_q[$];
    int          vectors = 0, fails = 0, mem_cnt = 0, rx_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    tdr_engine u_tdr_engine (
        .clk(clk), .rst(rst), .start(start), .demand(demand),
        .autopad_en(autopad_en), .ring_log(ring_log), .ring_base(ring_base),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .phy_err(phy_err),
        .tx_int(tx_int), .int_ack(int_ack)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: drives ready, sees accepted bytes, compares with scoreboard
    always @(negedge clk) begin
        lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = lfsr[0] | lfsr[1];
        phy_err  = '0;
        if (mem_en) mem_cnt++;
        if (tx_valid && tx_ready) begin
            rx_cnt++;
            if (exp_q.size() == 0) begin
                vectors++; fails++;
                $display("FAIL R3: actual unexpected byte %h expected none", tx_data);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                // R4 R5 R10: byte value and last flag
                check("R4/R5 byte", {23'd0, tx_last, tx_data}, {23'd0, e});
                if (tx_last && err_q.size() != 0) phy_err = err_q.pop_front();
            end
        end
    end

    function automatic logic [7:0] pat(input int seed, input int j);
        return 8'((seed + j * 7) & 8'hFF);
    endfunction

    function automatic logic [31:0] md1_sent(input int len, input logic [4:0] e);
        logic [31:0] w;
        w = {8'h03, 8'h00, 16'(-len)};
        w[30] = |e;
        return w;
    endfunction

    function automatic logic [31:0] rep_word(input logic [4:0] e);
        logic [31:0] w;
        w = '0;
        w[26] = e[0]; w[27] = e[1]; w[28] = e[2]; w[30] = e[3]; w[31] = e[4];
        return w;
    endfunction

    // Driver: lays out a descriptor and buffer, pushes expected bytes
    task automatic post(input int slot, input int len, input logic [4:0] e, input int seed);
        int bufw, total;
        bufw  = 64 + 32 * slot;
        total = (autopad_en && len < 60) ? 60 : len;
        for (int w = 0; w < (len + 3) / 4; w++) begin
            logic [31:0] v;
            for (int k = 0; k < 4; k++) v[8*k +: 8] = pat(seed, 4 * w + k);
            mem[bufw + w] = v;
        end
        mem[BASE + 4 * slot]     = 32'(bufw);
        mem[BASE + 4 * slot + 2] = '0;
        mem[BASE + 4 * slot + 1] = {8'h83, 8'h00, 16'(-len)};
        for (int j = 0; j < total; j++)
            exp_q.push_back({j == total - 1, (j < len) ? pat(seed, j) : 8'h00});
        err_q.push_back(e);
    endtask

    task automatic pulse_demand();
        @(negedge clk) demand = 1'b1;
        @(negedge clk) demand = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic check_desc(input string req, input int slot, input int len, input logic [4:0] e);
        check(req, mem[BASE + 4 * slot + 1], md1_sent(len, e));
        check(req, mem[BASE + 4 * slot + 2], rep_word(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        check("R1 tx_int", {31'd0, tx_int}, 32'd0);
        check("R1 mem_en", {31'd0, mem_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {30'd0, tx_valid, mem_en}, 32'd0);

        // R2: demand before start is ignored
        pulse_demand();
        repeat (20) @(negedge clk);
        check("R2 no access before start", 32'(mem_cnt), 32'd0);

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;

        // R5 pad to 60, R9 addressing at non-zero base
        autopad_en = 1'b1;
        post(0, 10, 5'b00000, 1);
        pulse_demand();
        drain();
        check_desc("R6/R9 slot0", 0, 10, 5'b00000);
        check("R7 tx_int set", {31'd0, tx_int}, 32'd1);
        @(negedge clk) int_ack = 1'b1;
        @(negedge clk) int_ack = 1'b0;
        check("R7 tx_int cleared", {31'd0, tx_int}, 32'd0);

        // R5 no pad, R8 back-to-back without new demand, R6 error bits
        autopad_en = 1'b0;
        post(1, 10, 5'b00100, 2);
        post(2, 70, 5'b11000, 3);
        pulse_demand();
        drain();
        check_desc("R6 slot1 lcol", 1, 10, 5'b00100);
        check_desc("R6 slot2 uflo buff", 2, 70, 5'b11000);

        // R3: owned entry without demand stays untouched
        post(3, 5, 5'b00011, 4);
        begin
            int m0;
            m0 = mem_cnt;
            repeat (40) @(negedge clk);
            check("R3 no poll without demand", 32'(mem_cnt - m0), 32'd0);
            check("R3 nothing sent", 32'(exp_q.size()), 32'd5);
        end
        pulse_demand();
        drain();
        check_desc("R6 slot3 rtry lcar", 3, 5, 5'b00011);

        // R8 wrap to entry 0, R5 above minimum
        autopad_en = 1'b1;
        post(0, 61, 5'b00000, 5);
        pulse_demand();
        drain();
        check_desc("R8 wrap slot0", 0, 61, 5'b00000);

        // R2 start returns index to 0 (index is 1 here)
        post(0, 59, 5'b10001, 6);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        pulse_demand();
        drain();
        check_desc("R2 start resets index", 0, 59, 5'b10001);
        check("R3 scoreboard empty", 32'(exp_q.size()), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule